// File: doc/BRIEF.md
# Memory DLL Bring-Up and Clock-Stop Sequencer

This block sits on the controller side of a synchronous memory that has an on-die delay-locked loop. It brings the memory up from cold and takes it down again. It also parks the memory clock during idle periods. On a start request it enables the core rail, then the I/O rail, then the reference-voltage rail, and lets each one settle for a set number of cycles. It then turns on the memory clock and waits for the clock to be stable. Only after that does it release the active-low DLL-disable line, and it then counts the DLL lock time before it raises `ready_o`. The controller issues no commands to the memory while `ready_o` is low.

A clock-stop request lowers `ready_o` and keeps the clock running until the controller reports that no read or write is in flight. Only then is the clock gated. When the request is withdrawn, the clock returns and the full lock count runs again before `ready_o` comes back. A shutdown request first drains outstanding work and then undoes the power-up steps in reverse order: DLL disabled, clock off, reference rail off, I/O rail off, core rail off.

The states are:
- OFF
- PU_VDD, PU_VDDQ, PU_VREF, PU_CLK (power-up steps)
- LOCK, RUN
- ST_DRAIN, STOPPED, RELOCK (clock stop and restart)
- PD_DRAIN, PD_DLL, PD_CLK, PD_VREF, PD_VDDQ, PD_VDD (power-down steps)

The transitions are:
- OFF to PU_VDD on start.
- PU_VDD to PU_VDDQ after the settle count.
- PU_VDDQ to PU_VREF after the settle count, or straight to PU_CLK when the reference rail is merged with the I/O rail.
- PU_VREF to PU_CLK after the settle count.
- PU_CLK to LOCK after the clock-stable count.
- LOCK to RUN after the lock count.
- RUN to PD_DRAIN on shutdown, or to ST_DRAIN on a stop request.
- ST_DRAIN to PD_DRAIN on shutdown, back to RUN if the stop request is withdrawn, or to STOPPED once the busy flag is low.
- STOPPED to PD_DLL on shutdown, or to RELOCK when the stop request is released.
- RELOCK to RUN after the lock count.
- PD_DRAIN to PD_DLL once the busy flag is low.
- PD_DLL to PD_CLK after the clock-stable count.
- PD_CLK to PD_VREF after the settle count, or straight to PD_VDDQ when the rails are merged.
- PD_VREF to PD_VDDQ, PD_VDDQ to PD_VDD, and PD_VDD to OFF, each after the settle count.

Top module: `mem_pwr_seq`

## Requirements
- R1: Power-up raises `vdd_en_o`, then `vddq_en_o`, then `vref_en_o`. Each state is held for SETTLE_CYCLES cycles before the next begins. With MERGE_VREF=1, `vref_en_o` rises together with `vddq_en_o` and the PU_VREF step is skipped.
- R2: `mem_clk_en_o` rises only once all three rails are on. It stays high with `dll_off_n_o` low for CLK_STABLE_CYCLES cycles before `dll_off_n_o` rises.
- R3: `ready_o` rises exactly LOCK_CYCLES (default 1024) cycles after the first cycle in which `dll_off_n_o` is high.
- R4: A shutdown from RUN waits until `busy_i` is low. It then lowers `dll_off_n_o` (clock still on, CLK_STABLE_CYCLES cycles), then `mem_clk_en_o`, then `vref_en_o`, then `vddq_en_o`, then `vdd_en_o`, with SETTLE_CYCLES cycles per step. It then returns to the all-low OFF state.
- R5: After a stop request, `mem_clk_en_o` stays high while `busy_i` is high. It falls in the cycle after `busy_i` is seen low, with `dll_off_n_o` still high.
- R6: Releasing the stop request while stopped re-enables the clock in the next cycle. `ready_o` returns 1025 cycles after the release is sampled (LOCK_CYCLES cycles of relock).
- R7: Withdrawing the stop request while still draining returns to RUN in the next cycle, with no clock stop and no relock.
- R8: `ready_o` is low in the cycle after a stop or shutdown request is sampled while `ready_o` is high.
- R9: `start_i` has no effect outside OFF. `shutdown_i` has no effect during the power-up steps, LOCK and RELOCK.
- R10: A shutdown while STOPPED goes directly to PD_DLL. The clock comes back on with `dll_off_n_o` low, and power-down continues as in R4.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin power-up (sampled in OFF) |
| shutdown_i | input | 1 | Begin drain and power-down |
| stop_req_i | input | 1 | Request clock stop; release to restart |
| busy_i | input | 1 | High while any read or write is outstanding |
| vdd_en_o | output | 1 | Core rail enable |
| vddq_en_o | output | 1 | I/O rail enable |
| vref_en_o | output | 1 | Reference-voltage rail enable |
| mem_clk_en_o | output | 1 | Memory clock gate enable |
| dll_off_n_o | output | 1 | DLL-disable line, low keeps the DLL off |
| ready_o | output | 1 | Memory locked; commands may be issued |

## Verification
Every output is a pure decode of the state register. A wrong state, or a dwell count that is off by one, therefore shows up on the rail, clock, DLL or ready pins in the very cycle the reference model expects a different step. The bench compares all six outputs of two configurations (rails separate and rails merged) against a behavioural model on every cycle. A stray extra lock cycle, a clock gated while busy, or a skipped power-down step is caught at the first edge where it appears. Relock timing is also checked end to end, by counting cycles from the stop release to `ready_o`.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PU_VDD,
        ST_PU_VDDQ,
        ST_PU_VREF,
        ST_PU_CLK,
        ST_LOCK,
        ST_RUN,
        ST_ST_DRAIN,
        ST_STOPPED,
        ST_RELOCK,
        ST_PD_DRAIN,
        ST_PD_DLL,
        ST_PD_CLK,
        ST_PD_VREF,
        ST_PD_VDDQ,
        ST_PD_VDD
    } seq_state_t;

    typedef enum logic [1:0] {
        DW_NONE,
        DW_SETTLE,
        DW_CLK,
        DW_LOCK
    } dwell_t;

    typedef struct packed {
        logic vdd;
        logic vddq;
        logic vref;
        logic clk;
        logic dll_on;
        logic ready;
    } seq_out_t;

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer
    import mem_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES     = 16,
    parameter int CLK_STABLE_CYCLES = 8,
    parameter int LOCK_CYCLES       = 1024
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear_i,
    input  dwell_t dwell_i,
    output logic   expired_o
);
    localparam int MAX_A = (SETTLE_CYCLES > CLK_STABLE_CYCLES) ? SETTLE_CYCLES : CLK_STABLE_CYCLES;
    localparam int MAX_L = (MAX_A > LOCK_CYCLES) ? MAX_A : LOCK_CYCLES;
    localparam int W     = (MAX_L > 1) ? $clog2(MAX_L + 1) : 1;
    localparam logic [W-1:0] LAST_SET  = W'(SETTLE_CYCLES - 1);
    localparam logic [W-1:0] LAST_CLK  = W'(CLK_STABLE_CYCLES - 1);
    localparam logic [W-1:0] LAST_LOCK = W'(LOCK_CYCLES - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    always_comb begin
        unique case (dwell_i)
            DW_SETTLE: last = LAST_SET;
            DW_CLK:    last = LAST_CLK;
            DW_LOCK:   last = LAST_LOCK;
            default:   last = '0;
        endcase
    end

    assign expired_o = (dwell_i != DW_NONE) && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || dwell_i == DW_NONE) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_i != DW_NONE && !clear_i) |-> (cnt_q <= last)); // R3

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import mem_seq_pkg::*;
#(
    parameter bit MERGE_VREF = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       shutdown_i,
    input  logic       stop_req_i,
    input  logic       busy_i,
    input  logic       expired_i,
    output seq_state_t state_o,
    output logic       advance_o,
    output dwell_t     dwell_o
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:      if (start_i) state_d = ST_PU_VDD;
            ST_PU_VDD:   if (expired_i) state_d = ST_PU_VDDQ;
            ST_PU_VDDQ:  if (expired_i) state_d = MERGE_VREF ? ST_PU_CLK : ST_PU_VREF;
            ST_PU_VREF:  if (expired_i) state_d = ST_PU_CLK;
            ST_PU_CLK:   if (expired_i) state_d = ST_LOCK;
            ST_LOCK:     if (expired_i) state_d = ST_RUN;
            ST_RUN: begin
                if (shutdown_i)      state_d = ST_PD_DRAIN;
                else if (stop_req_i) state_d = ST_ST_DRAIN;
            end
            ST_ST_DRAIN: begin
                if (shutdown_i)       state_d = ST_PD_DRAIN;
                else if (!stop_req_i) state_d = ST_RUN;
                else if (!busy_i)     state_d = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (shutdown_i)       state_d = ST_PD_DLL;
                else if (!stop_req_i) state_d = ST_RELOCK;
            end
            ST_RELOCK:   if (expired_i) state_d = ST_RUN;
            ST_PD_DRAIN: if (!busy_i) state_d = ST_PD_DLL;
            ST_PD_DLL:   if (expired_i) state_d = ST_PD_CLK;
            ST_PD_CLK:   if (expired_i) state_d = MERGE_VREF ? ST_PD_VDDQ : ST_PD_VREF;
            ST_PD_VREF:  if (expired_i) state_d = ST_PD_VDDQ;
            ST_PD_VDDQ:  if (expired_i) state_d = ST_PD_VDD;
            ST_PD_VDD:   if (expired_i) state_d = ST_OFF;
            default:     state_d = ST_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_PU_VDD, ST_PU_VDDQ, ST_PU_VREF,
            ST_PD_CLK, ST_PD_VREF, ST_PD_VDDQ, ST_PD_VDD: dwell_o = DW_SETTLE;
            ST_PU_CLK, ST_PD_DLL:                         dwell_o = DW_CLK;
            ST_LOCK, ST_RELOCK:                           dwell_o = DW_LOCK;
            default:                                      dwell_o = DW_NONE;
        endcase
    end

    assign advance_o = (state_d != state_q);
    assign state_o   = state_q;

    AST_NO_STOP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ST_DRAIN && busy_i && stop_req_i && !shutdown_i) |=> (state_q == ST_ST_DRAIN)); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !expired_i) |=> (state_q == ST_LOCK)); // R9

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
    import mem_seq_pkg::*;
#(
    parameter bit MERGE_VREF = 1'b0
) (
    input  seq_state_t state_i,
    output seq_out_t   out_o
);
    always_comb begin
        out_o = '0;
        unique case (state_i)
            ST_OFF, ST_PD_VDD: out_o = '0;
            ST_PU_VDD, ST_PD_VDDQ: begin
                out_o.vdd = 1'b1;
            end
            ST_PU_VDDQ: begin
                out_o.vdd  = 1'b1;
                out_o.vddq = 1'b1;
                out_o.vref = MERGE_VREF;
            end
            ST_PD_VREF: begin
                out_o.vdd  = 1'b1;
                out_o.vddq = 1'b1;
            end
            ST_PU_VREF, ST_PD_CLK: begin
                out_o.vdd  = 1'b1;
                out_o.vddq = 1'b1;
                out_o.vref = 1'b1;
            end
            ST_PU_CLK, ST_PD_DLL: begin
                out_o.vdd  = 1'b1;
                out_o.vddq = 1'b1;
                out_o.vref = 1'b1;
                out_o.clk  = 1'b1;
            end
            ST_LOCK, ST_ST_DRAIN, ST_RELOCK, ST_PD_DRAIN: begin
                out_o.vdd    = 1'b1;
                out_o.vddq   = 1'b1;
                out_o.vref   = 1'b1;
                out_o.clk    = 1'b1;
                out_o.dll_on = 1'b1;
            end
            ST_STOPPED: begin
                out_o.vdd    = 1'b1;
                out_o.vddq   = 1'b1;
                out_o.vref   = 1'b1;
                out_o.dll_on = 1'b1;
            end
            ST_RUN: begin
                out_o.vdd    = 1'b1;
                out_o.vddq   = 1'b1;
                out_o.vref   = 1'b1;
                out_o.clk    = 1'b1;
                out_o.dll_on = 1'b1;
                out_o.ready  = 1'b1;
            end
            default: out_o = '0;
        endcase
    end

endmodule

// File: rtl/mem_pwr_seq.sv
module mem_pwr_seq
    import mem_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES     = 16,
    parameter int CLK_STABLE_CYCLES = 8,
    parameter int LOCK_CYCLES       = 1024,
    parameter bit MERGE_VREF        = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic shutdown_i,
    input  logic stop_req_i,
    input  logic busy_i,
    output logic vdd_en_o,
    output logic vddq_en_o,
    output logic vref_en_o,
    output logic mem_clk_en_o,
    output logic dll_off_n_o,
    output logic ready_o
);
    localparam int LW = $clog2(LOCK_CYCLES + 1);

    seq_state_t state;
    dwell_t     dwell;
    logic       advance;
    logic       expired;
    seq_out_t   outs;

    seq_fsm #(
        .MERGE_VREF(MERGE_VREF)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .shutdown_i (shutdown_i),
        .stop_req_i (stop_req_i),
        .busy_i     (busy_i),
        .expired_i  (expired),
        .state_o    (state),
        .advance_o  (advance),
        .dwell_o    (dwell)
    );

    seq_dwell_timer #(
        .SETTLE_CYCLES     (SETTLE_CYCLES),
        .CLK_STABLE_CYCLES (CLK_STABLE_CYCLES),
        .LOCK_CYCLES       (LOCK_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (advance),
        .dwell_i   (dwell),
        .expired_o (expired)
    );

    seq_out_decode #(
        .MERGE_VREF(MERGE_VREF)
    ) u_dec (
        .state_i (state),
        .out_o   (outs)
    );

    assign vdd_en_o     = outs.vdd;
    assign vddq_en_o    = outs.vddq;
    assign vref_en_o    = outs.vref;
    assign mem_clk_en_o = outs.clk;
    assign dll_off_n_o  = outs.dll_on;
    assign ready_o      = outs.ready;

    // Independent observer: cycles the DLL has seen a running clock while enabled.
    logic [LW-1:0] lock_obs;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_obs <= '0;
        end else if (!(mem_clk_en_o && dll_off_n_o)) begin
            lock_obs <= '0;
        end else if (lock_obs != LW'(LOCK_CYCLES)) begin
            lock_obs <= lock_obs + 1'b1;
        end
    end

    AST_VDDQ_NEEDS_VDD: assert property (@(posedge clk) disable iff (!rst_n)
        vddq_en_o |-> vdd_en_o); // R1

    AST_VREF_NEEDS_VDDQ: assert property (@(posedge clk) disable iff (!rst_n)
        vref_en_o |-> vddq_en_o); // R1

    AST_CLK_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_en_o |-> (vdd_en_o && vddq_en_o && vref_en_o)); // R2

    AST_DLL_RISE_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_off_n_o) |-> (mem_clk_en_o && $past(mem_clk_en_o))); // R2

    AST_READY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (lock_obs == LW'(LOCK_CYCLES))); // R3

    AST_STOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_clk_en_o) && dll_off_n_o) |-> !$past(busy_i)); // R5

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (stop_req_i || shutdown_i)) |=> !ready_o); // R8

    AST_VREF_OFF_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vref_en_o) |-> (!mem_clk_en_o && !dll_off_n_o)); // R4

endmodule

// File: tb/test_mem_pwr_seq.sv
module seq_ref_model #(
    parameter int SET = 5,
    parameter int CST = 4,
    parameter int LCK = 1024,
    parameter bit MRG = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       shut,
    input  logic       stop,
    input  logic       busy,
    output logic [5:0] expv,
    output int         ph
);
    int left;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= 0;
            left <= 0;
        end else begin
            case (ph)
                0: if (start) begin ph <= 1; left <= SET; end
                1: if (left > 1) left <= left - 1; else begin ph <= 2; left <= SET; end
                2: if (left > 1) left <= left - 1;
                   else if (MRG) begin ph <= 4; left <= CST; end
                   else begin ph <= 3; left <= SET; end
                3: if (left > 1) left <= left - 1; else begin ph <= 4; left <= CST; end
                4: if (left > 1) left <= left - 1; else begin ph <= 5; left <= LCK; end
                5: if (left > 1) left <= left - 1; else ph <= 6;
                6: if (shut) ph <= 10; else if (stop) ph <= 7;
                7: if (shut) ph <= 10; else if (!stop) ph <= 6; else if (!busy) ph <= 8;
                8: if (shut) begin ph <= 11; left <= CST; end
                   else if (!stop) begin ph <= 9; left <= LCK; end
                9: if (left > 1) left <= left - 1; else ph <= 6;
                10: if (!busy) begin ph <= 11; left <= CST; end
                11: if (left > 1) left <= left - 1; else begin ph <= 12; left <= SET; end
                12: if (left > 1) left <= left - 1;
                    else if (MRG) begin ph <= 14; left <= SET; end
                    else begin ph <= 13; left <= SET; end
                13: if (left > 1) left <= left - 1; else begin ph <= 14; left <= SET; end
                14: if (left > 1) left <= left - 1; else begin ph <= 15; left <= SET; end
                15: if (left > 1) left <= left - 1; else ph <= 0;
                default: ph <= 0;
            endcase
        end
    end

    // {vdd, vddq, vref, clk, dll_on, ready}
    always @* begin
        case (ph)
            1, 14:        expv = 6'b100000;
            2:            expv = MRG ? 6'b111000 : 6'b110000;
            13:           expv = 6'b110000;
            3, 12:        expv = 6'b111000;
            4, 11:        expv = 6'b111100;
            5, 7, 9, 10:  expv = 6'b111110;
            8:            expv = 6'b111010;
            6:            expv = 6'b111111;
            default:      expv = 6'b000000;
        endcase
    end
endmodule

module test_mem_pwr_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, shut = 1'b0, stop = 1'b0, busy = 1'b0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    logic [5:0] act_a, act_b, exp_a, exp_b;
    int ph_a, ph_b;

    mem_pwr_seq #(.SETTLE_CYCLES(5), .CLK_STABLE_CYCLES(4), .LOCK_CYCLES(1024), .MERGE_VREF(1'b0)) i_mem_pwr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(shut), .stop_req_i(stop), .busy_i(busy),
        .vdd_en_o(act_a[5]), .vddq_en_o(act_a[4]), .vref_en_o(act_a[3]),
        .mem_clk_en_o(act_a[2]), .dll_off_n_o(act_a[1]), .ready_o(act_a[0]));

    mem_pwr_seq #(.SETTLE_CYCLES(5), .CLK_STABLE_CYCLES(4), .LOCK_CYCLES(1024), .MERGE_VREF(1'b1)) i_mem_pwr_seq_m (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(shut), .stop_req_i(stop), .busy_i(busy),
        .vdd_en_o(act_b[5]), .vddq_en_o(act_b[4]), .vref_en_o(act_b[3]),
        .mem_clk_en_o(act_b[2]), .dll_off_n_o(act_b[1]), .ready_o(act_b[0]));

    seq_ref_model #(.SET(5), .CST(4), .LCK(1024), .MRG(1'b0)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .start(start), .shut(shut), .stop(stop), .busy(busy), .expv(exp_a), .ph(ph_a));
    seq_ref_model #(.SET(5), .CST(4), .LCK(1024), .MRG(1'b1)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .start(start), .shut(shut), .stop(stop), .busy(busy), .expv(exp_b), .ph(ph_b));

    function automatic string ph_tag(int p);
        case (p)
            0:          return "R11";
            1, 2, 3:    return "R1";
            4:          return "R2";
            5:          return "R3";
            6:          return "R8";
            7, 8:       return "R5";
            9:          return "R6";
            default:    return "R4";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [5:0] act, logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of both configurations against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(ph_tag(ph_a), "split-rail outputs", act_a, exp_a);
            chk(ph_tag(ph_b), "merged-rail outputs", act_b, exp_b);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_ready(string tag);
        int n = 0;
        while (!(act_a[0] && act_b[0]) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, "ready reached", {5'b0, act_a[0] & act_b[0]}, 6'b000001);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R3 watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        cyc(3);
        chk("R11", "outputs in reset", act_a, 6'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R11", "outputs after reset", act_a, 6'b0);

        // Power-up
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        chk("R1", "core rail first", act_a, 6'b100000);
        shut = 1'b1; start = 1'b1;      // R9: ignored during power-up
        cyc(2);
        shut = 1'b0; start = 1'b0;
        cyc(3);                         // negedge 6: first PU_VDDQ cycle
        chk("R1", "io rail, vref still off", act_a, 6'b110000);
        chk("R1", "merged vref with io rail", act_b, 6'b111000);
        chk("R9", "power-up continues despite shutdown", {5'b0, act_a[4]}, 6'b000001);
        cyc(10);                        // negedge 16: first PU_CLK cycle of split config
        chk("R2", "clock on, dll held off", act_a, 6'b111100);
        wait_ready("R3");

        // Clock stop with outstanding work
        busy = 1'b1; stop = 1'b1;
        cyc(1);
        chk("R8", "ready drops after stop request", {5'b0, act_a[0]}, 6'b0);
        cyc(9);
        chk("R5", "clock held while busy", act_a, 6'b111110);
        busy = 1'b0;
        cyc(1);
        chk("R5", "clock gated, dll kept on", act_a, 6'b111010);
        cyc(5);

        // Restart with relock count
        stop = 1'b0;
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!act_a[0] && n < 3000);
            chk("R6", "relock length", n[5:0], 6'(1025));
            total++;
            if (n != 1025) begin
                bad++;
                $display("FAIL R6 relock cycles: actual=%0d expected=1025", n);
            end
        end
        wait_ready("R6");

        // Stop withdrawn during drain
        busy = 1'b1; stop = 1'b1;
        cyc(4);
        stop = 1'b0;
        cyc(1);
        chk("R7", "back to ready without relock", act_a, 6'b111111);
        busy = 1'b0;
        cyc(2);

        // Stop, then shutdown from stopped
        stop = 1'b1;
        cyc(4);
        chk("R5", "stopped", act_a, 6'b111010);
        shut = 1'b1;
        cyc(1);
        chk("R10", "clock back with dll disabled", act_a, 6'b111100);
        shut = 1'b0; stop = 1'b0;
        cyc(4);
        chk("R4", "clock off after dll step", act_a, 6'b111000);
        cyc(5);
        chk("R4", "vref off next", act_a, 6'b110000);
        cyc(30);
        chk("R4", "all off after power-down", act_a, 6'b0);
        chk("R4", "merged all off", act_b, 6'b0);

        // Second power-up, shutdown with a drain
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        wait_ready("R3");
        busy = 1'b1; shut = 1'b1;
        cyc(1);
        chk("R8", "ready drops after shutdown", {5'b0, act_a[0]}, 6'b0);
        cyc(5);
        chk("R4", "clock and dll kept while draining", act_a, 6'b111110);
        busy = 1'b0; shut = 1'b0;
        cyc(1);
        chk("R4", "dll disabled first", act_a, 6'b111100);
        cyc(40);
        chk("R4", "rails off at end", act_a, 6'b0);
        start = 1'b1;                   // R9 sanity: start from OFF works again
        cyc(1);
        start = 1'b0;
        chk("R9", "start accepted only in off", act_a, 6'b100000);
        cyc(3);
        summary();
    end
endmodule